// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

This block is a bus-attached watchdog timer for a processor subsystem. Software programs a 32-bit timeout constant and sets an enable bit, and optionally a reset-enable bit. It then starts the countdown with a feed. A feed is valid only when a two-byte key is written to the feed register in a fixed order. The down-counter then runs one step per clock. If software fails to feed again before the counter empties, the block raises a sticky timeout flag. If reset-enable is set, it also asserts a single-cycle reset request to the system reset generator.

The key sequence guards against runaway code. After the first key byte, the very next access to any watchdog register must be the second key byte written to the feed register. Any other access at that point, including a read, is a fault and trips the watchdog at once. Idle cycles with no watchdog access may pass between the two key writes.

The bus is a single-cycle register port. An access is presented for one clock with `regSel` high and is taken at the rising edge. Read data is combinational while a read is presented. Writes reach the registers on that edge.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `wdTimeout` and `wdResetReq` are 0. The timeout register (address 0) reads 0x000000FF, the mode register (address 1) reads 0, and the count register (address 3) reads 0.
- R2: Writing 0xAA and then 0x55 to the feed register (address 2; only data bits 7:0 are compared) loads the timeout constant into the counter, while enabled. Cycles with no access may separate the two writes. A read of address 3 in the cycle after the 0x55 write returns the constant. A repeated feed before expiry prevents a timeout.
- R3: Once loaded, the counter drops by one on every clock. The timeout fires in the cycle after the counter reads 0. With constant C, the flag is set on the (C+2)-th rising edge after the loading edge, counting the loading edge as edge 1. Counting then stops until the next valid feed.
- R4: While enabled, if the access that follows a 0xAA feed write is anything other than a 0x55 feed write, it is a fault. This covers a read, a write to another register, and another 0xAA. The flag is set on that access's clock edge.
- R5: While enabled and with no 0xAA pending, a feed write whose low byte is not 0xAA is a fault. This includes a lone 0x55.
- R6: While the enable bit is 0, feed writes have no effect. The flag stays 0 and the counter stays at 0.
- R7: The enable bit (mode bit 0) can be set by software but not cleared. Writing 0 to the mode register leaves it at 1.
- R8: A timeout or fault sets `wdTimeout`, which stays set until system reset. On the same edge, `wdResetReq` is asserted for exactly one cycle, but only if reset-enable (mode bit 1) is 1.
- R9: A timeout-constant write below 0xFF stores 0xFF. Any value from 0xFF to 0xFFFFFFFF is stored unchanged.
- R10: Setting the enable bit alone does not start counting. The count register stays 0 until the first valid feed.
- R11: Mode register readback gives bit 0 enable, bit 1 reset-enable and bit 2 the timeout flag. Writes to bit 2 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous system reset |
| regSel | input | 1 | Access strobe, one cycle per access |
| regWr | input | 1 | 1 = write, 0 = read |
| regAddr | input | 2 | 0 timeout constant, 1 mode, 2 feed, 3 count |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid while a read is presented, else 0 |
| wdTimeout | output | 1 | Sticky timeout/fault flag |
| wdResetReq | output | 1 | One-cycle reset request |

## Verification
Every result is registered once behind the access that causes it. A fault, the flag and the reset pulse appear on the edge that takes the offending access. A loaded count is visible to a read presented in the very next cycle. Expiry shows on the (C+2)-th edge after the loading edge.

The bench drives each access at a falling edge and samples read data 1 ns later, before the next rising edge. It checks `wdTimeout` and `wdResetReq` at falling edges counted from the feed. At C = 0xFF this gives one check at edge 256 expecting no flag and one at edge 257 expecting flag and pulse. A further check one edge later confirms the pulse has dropped and the flag has held.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    ADDR_TCONST = 2'd0,
    ADDR_MODE   = 2'd1,
    ADDR_FEED   = 2'd2,
    ADDR_COUNT  = 2'd3
  } wdAddr_e;

  typedef enum logic {
    FEED_IDLE  = 1'b0,
    FEED_ARMED = 1'b1
  } feedState_e;

  typedef struct packed {
    logic tcWrite;
    logic reload;
  } dpStrobe_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [7:0] KEY_FIRST = 8'hAA,
  parameter logic [7:0] KEY_SECOND = 8'h55
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regSel,
  input  logic             regWr,
  input  logic [1:0]       regAddr,
  input  logic [7:0]       keyByte,
  input  logic [CNT_W-1:0] cntVal,
  input  logic [CNT_W-1:0] tcVal,
  input  logic             expire,
  output dpStrobe_t        strobe,
  output logic [CNT_W-1:0] regRdata,
  output logic             wdTimeout,
  output logic             wdResetReq
);
  localparam int MODE_PAD = CNT_W - 3;

  feedState_e state, nextState;
  logic enable, rstEn, fault, reload;
  logic feedWr, modeWr, tcWr;

  assign feedWr = regSel & regWr & (regAddr == ADDR_FEED);
  assign modeWr = regSel & regWr & (regAddr == ADDR_MODE);
  assign tcWr   = regSel & regWr & (regAddr == ADDR_TCONST);

  always_comb begin
    nextState = state;
    reload    = 1'b0;
    fault     = 1'b0;
    if (enable && regSel) begin
      unique case (state)
        FEED_IDLE: begin
          if (feedWr) begin
            if (keyByte == KEY_FIRST) nextState = FEED_ARMED;
            else                      fault = 1'b1;
          end
        end
        FEED_ARMED: begin
          nextState = FEED_IDLE;
          if (feedWr && keyByte == KEY_SECOND) reload = 1'b1;
          else                                 fault  = 1'b1;
        end
        default: nextState = FEED_IDLE;
      endcase
    end
  end

  assign strobe.reload  = reload;
  assign strobe.tcWrite = tcWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= FEED_IDLE;
      enable     <= 1'b0;
      rstEn      <= 1'b0;
      wdTimeout  <= 1'b0;
      wdResetReq <= 1'b0;
    end else begin
      state      <= nextState;
      enable     <= enable | (modeWr & keyByte[0]);
      if (modeWr) rstEn <= keyByte[1];
      wdTimeout  <= wdTimeout | fault | expire;
      wdResetReq <= rstEn & (fault | expire);
    end
  end

  always_comb begin
    regRdata = '0;
    if (regSel && !regWr) begin
      unique case (regAddr)
        ADDR_TCONST: regRdata = tcVal;
        ADDR_MODE:   regRdata = {{MODE_PAD{1'b0}}, wdTimeout, rstEn, enable};
        ADDR_FEED:   regRdata = '0;
        ADDR_COUNT:  regRdata = cntVal;
        default:     regRdata = '0;
      endcase
    end
  end

  // R7: enable never falls without reset
  p_enable_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    enable |=> enable);
  // R8: flag holds until reset
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    wdTimeout |=> wdTimeout);
  // R8: a reset request always comes with the flag
  p_req_with_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    wdResetReq |-> wdTimeout);
  // R6: the key sequence never arms while disabled
  p_idle_disabled_r6: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> state == FEED_IDLE);
  // R4: a wrong access after the first key trips the flag
  p_armed_fault_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regSel && state == FEED_ARMED && !(feedWr && keyByte == KEY_SECOND)) |=> wdTimeout);
endmodule

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] TC_MIN = 'hFF
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] tcVal,
  output logic             expire
);
  logic running;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tcVal <= TC_MIN;
    end else if (strobe.tcWrite) begin
      tcVal <= (wrData < TC_MIN) ? TC_MIN : wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntVal  <= '0;
      running <= 1'b0;
    end else if (strobe.reload) begin
      cntVal  <= tcVal;
      running <= 1'b1;
    end else if (running) begin
      if (cntVal == '0) running <= 1'b0;
      else              cntVal  <= cntVal - 1'b1;
    end
  end

  assign expire = running & (cntVal == '0) & ~strobe.reload;

  // R9: the stored constant never drops below the floor
  p_tc_floor_r9: assert property (@(posedge clk) disable iff (!rstN)
    tcVal >= TC_MIN);
  // R3: one step down per clock while running
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (running && cntVal != '0 && !strobe.reload) |=> cntVal == $past(cntVal) - 1'b1);
  // R2: a valid feed loads the constant
  p_reload_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> (cntVal == $past(tcVal)) && running);
  // R3: counting halts after expiry
  p_halt_r3: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> !running);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [7:0] KEY_FIRST = 8'hAA,
  parameter logic [7:0] KEY_SECOND = 8'h55,
  parameter logic [CNT_W-1:0] TC_MIN = 'hFF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regSel,
  input  logic             regWr,
  input  logic [1:0]       regAddr,
  input  logic [CNT_W-1:0] regWdata,
  output logic [CNT_W-1:0] regRdata,
  output logic             wdTimeout,
  output logic             wdResetReq
);
  dpStrobe_t        strobe;
  logic [CNT_W-1:0] cntVal, tcVal;
  logic             expire;

  wdog_ctrl #(.CNT_W(CNT_W), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regAddr(regAddr),
    .keyByte(regWdata[7:0]), .cntVal(cntVal), .tcVal(tcVal), .expire(expire),
    .strobe(strobe), .regRdata(regRdata), .wdTimeout(wdTimeout), .wdResetReq(wdResetReq)
  );

  wdog_dp #(.CNT_W(CNT_W), .TC_MIN(TC_MIN)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWdata),
    .cntVal(cntVal), .tcVal(tcVal), .expire(expire)
  );
endmodule

// File: tb/keyed_watchdog_tb.sv
module keyed_watchdog_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regSel = 1'b0, regWr = 1'b0;
  logic [1:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic wdTimeout, wdResetReq;
  int nChecks = 0, nFails = 0;
  logic [31:0] rv;

  keyed_watchdog u_dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .wdTimeout(wdTimeout), .wdResetReq(wdResetReq)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    regSel = 1'b1; regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regSel = 1'b0; regWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regSel = 1'b1; regWr = 1'b0; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regSel = 1'b0;
  endtask

  task automatic do_reset();
    rstN = 1'b0; regSel = 1'b0;
    idle(2);
    rstN = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 timeout", {31'b0, wdTimeout}, 0);
    check("R1 resetReq", {31'b0, wdResetReq}, 0);
    rd(2'd0, rv); check("R1 tconst", rv, 32'hFF);
    rd(2'd1, rv); check("R1 mode", rv, 0);
    rd(2'd3, rv); check("R1 count", rv, 0);
  endtask

  task automatic t_disabled_r6();
    do_reset();
    wr(2'd2, 32'h12); wr(2'd2, 32'hAA); wr(2'd2, 32'h55);
    idle(3);
    check("R6 flag", {31'b0, wdTimeout}, 0);
    rd(2'd3, rv); check("R6 count", rv, 0);
  endtask

  task automatic t_enable_only_r10();
    do_reset();
    wr(2'd1, 32'h3);
    idle(20);
    rd(2'd3, rv); check("R10 count idle", rv, 0);
    check("R10 flag", {31'b0, wdTimeout}, 0);
  endtask

  task automatic t_feed_gap_r2();
    do_reset();
    wr(2'd0, 32'h1000); wr(2'd1, 32'h1);
    wr(2'd2, 32'hAA); idle(5); wr(2'd2, 32'h55);
    rd(2'd3, rv); check("R2 loaded", rv, 32'h1000);
    rd(2'd3, rv); check("R3 decrement", rv, 32'h0FFF);
    check("R2 no flag", {31'b0, wdTimeout}, 0);
  endtask

  task automatic t_timeout_r3();
    do_reset();
    wr(2'd0, 32'h10);
    rd(2'd0, rv); check("R9 clamp", rv, 32'hFF);
    wr(2'd1, 32'h3);
    wr(2'd2, 32'hAA); wr(2'd2, 32'h55);
    idle(255);
    check("R3 not yet", {31'b0, wdTimeout}, 0);
    idle(1);
    check("R3 flag", {31'b0, wdTimeout}, 1);
    check("R8 pulse", {31'b0, wdResetReq}, 1);
    idle(1);
    check("R8 pulse one cycle", {31'b0, wdResetReq}, 0);
    check("R8 sticky", {31'b0, wdTimeout}, 1);
    rd(2'd1, rv); check("R11 mode readback", rv, 32'h7);
    rd(2'd3, rv); check("R3 halted", rv, 0);
  endtask

  task automatic t_refeed_r2();
    do_reset();
    wr(2'd1, 32'h1);
    wr(2'd2, 32'hAA); wr(2'd2, 32'h55);
    idle(200);
    wr(2'd2, 32'hAA); wr(2'd2, 32'h55);
    idle(200);
    check("R2 refeed holds off", {31'b0, wdTimeout}, 0);
    idle(60);
    check("R3 later expiry", {31'b0, wdTimeout}, 1);
  endtask

  task automatic t_interleave_r4();
    do_reset();
    wr(2'd1, 32'h3); wr(2'd2, 32'hAA); rd(2'd1, rv);
    check("R4 read between keys", {31'b0, wdTimeout}, 1);
    check("R8 req on fault", {31'b0, wdResetReq}, 1);
    do_reset();
    wr(2'd1, 32'h1); wr(2'd2, 32'hAA); wr(2'd0, 32'h200);
    check("R4 tconst write between keys", {31'b0, wdTimeout}, 1);
    do_reset();
    wr(2'd1, 32'h1); wr(2'd2, 32'hAA); wr(2'd2, 32'hAA);
    check("R4 double first key", {31'b0, wdTimeout}, 1);
  endtask

  task automatic t_bad_key_r5();
    do_reset();
    wr(2'd1, 32'h1); wr(2'd2, 32'h55);
    check("R5 lone second key", {31'b0, wdTimeout}, 1);
    check("R8 no req when disabled", {31'b0, wdResetReq}, 0);
    do_reset();
    wr(2'd1, 32'h1); wr(2'd2, 32'h3C);
    check("R5 wrong key", {31'b0, wdTimeout}, 1);
  endtask

  task automatic t_sticky_enable_r7();
    do_reset();
    wr(2'd1, 32'h3); wr(2'd1, 32'h4);
    rd(2'd1, rv); check("R7 enable kept, R11 bit2 ignored", rv, 32'h1);
  endtask

  task automatic t_tconst_r9();
    do_reset();
    wr(2'd0, 32'hFFFFFFFF); rd(2'd0, rv); check("R9 full scale", rv, 32'hFFFFFFFF);
    wr(2'd0, 32'hFE); rd(2'd0, rv); check("R9 below floor", rv, 32'hFF);
    wr(2'd0, 32'h100); rd(2'd0, rv); check("R9 above floor", rv, 32'h100);
  endtask

  initial begin
    #(8 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_disabled_r6();
    t_enable_only_r10();
    t_feed_gap_r2();
    t_timeout_r3();
    t_refeed_r2();
    t_interleave_r4();
    t_bad_key_r5();
    t_sticky_enable_r7();
    t_tconst_r9();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule